// File: doc/BRIEF.md
# Stereo Volume Ramp and Mixer

This block is the digital gain stage of a two-channel audio output path. On each sample strobe it takes a signed left and right sample, forms each output channel from a selectable mix of the two inputs, and scales the result by an attenuation that is set in whole decibels. A channel can be muted, and a flag tells the analog side which channels are currently silenced.

The attenuation codes come from configuration registers. A change in level can take effect at once. It can instead walk toward the new value one decibel per sample. It can also be held back until the channel's waveform crosses zero, so that the jump in level makes no audible click. When the signal never crosses zero, a sample-count timeout forces the change through. The two channels track their targets and their zero crossings independently.

Top module: `vr_stereo_gain`

## Requirements
- R1: For a code c from 0 to MAX_DB (90), the gain is M[c mod 6] >> (c div 6) in Q16 form, with M = {65536, 58409, 52057, 46396, 41350, 36854}. The output is floor(mixed * gain / 65536).
- R2: A level code above MAX_DB (91 to 127) drives that channel's output to zero.
- R3: The select encoding for a channel is 0 = silence, 1 = own input (left for A, right for B), 2 = opposite input, 3 = floor((L+R)/2). The average is formed one bit wider, so full-scale inputs do not overflow.
- R4: A set channel mute bit drives that channel's output to zero. The mute flag of a channel is 1 from the clock after its mute bit is 1 or its select is 0. It falls back to 0 the clock after neither holds.
- R5: Outputs are registered. A strobe's result appears the clock after the strobe, with out_valid high for exactly that clock. Between strobes the outputs hold their values.
- R6: In update mode 0 (immediate), the target code applies to the sample presented with the same strobe. The level changes only on strobes.
- R7: In update mode 1 (ramp), each strobe moves the level one code toward the target, and the new level already scales that strobe's sample.
- R8: In update mode 2 (zero cross), a pending change applies on a strobe whose mixed sample sign (bit 23) differs from the previous strobe's mixed sample of the same channel. Each channel is judged on its own samples.
- R9: In modes 2 and 3, a pending change with no crossing is forced on the TIMEOUT-th consecutive pending strobe (default 512, legal range 512 to 1024).
- R10: In update mode 3 (ramp with zero cross), each single-code step waits for a crossing or for the timeout.
- R11: Reset clears the outputs, the flags and out_valid, sets both levels to code 0 (0 dB), and sets the previous-sample signs to non-negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe, one clock per stereo sample |
| in_l | input | 24 | Left input sample, signed |
| in_r | input | 24 | Right input sample, signed |
| atten_a | input | 7 | Channel A target attenuation code, in dB |
| atten_b | input | 7 | Channel B target attenuation code, in dB |
| mix_a | input | 2 | Channel A source select |
| mix_b | input | 2 | Channel B source select |
| upd_mode | input | 2 | Level update style, 0 to 3 |
| mute_a | input | 1 | Channel A mute |
| mute_b | input | 1 | Channel B mute |
| out_valid | output | 1 | Output sample strobe |
| out_a | output | 24 | Channel A output, signed |
| out_b | output | 24 | Channel B output, signed |
| mute_flag_a | output | 1 | Channel A silenced |
| mute_flag_b | output | 1 | Channel B silenced |

## Verification
A level update and a sign change can land on the same strobe. The design must then scale that crossing sample with the new gain, not the old one. The bench provokes this by flipping the input sign on the strobe after a target change and expecting the new gain on that exact output. It also flips one channel's sign while holding the other steady, to show that the held channel keeps its old gain. The ramp-with-crossing mode is judged the same way, one code per crossing strobe.

// File: rtl/vr_pkg.sv
package vr_pkg;

   typedef enum logic [1:0] {
      SRC_MUTE  = 2'd0,
      SRC_OWN   = 2'd1,
      SRC_CROSS = 2'd2,
      SRC_AVG   = 2'd3
   } src_sel_e;

   typedef enum logic [1:0] {
      UPD_NOW     = 2'd0,
      UPD_RAMP    = 2'd1,
      UPD_ZC      = 2'd2,
      UPD_RAMP_ZC = 2'd3
   } upd_mode_e;

   localparam int GAIN_FRAC  = 16;
   localparam int DB_PER_OCT = 6;

   // Q16 gain for one decibel code; every 6 dB halves the mantissa
   function automatic logic [GAIN_FRAC:0] gain_q(input int unsigned code,
                                                 input int unsigned max_db);
      logic [GAIN_FRAC:0] mant;
      if (code > max_db) return '0;
      case (code % DB_PER_OCT)
         0:       mant = 17'd65536;
         1:       mant = 17'd58409;
         2:       mant = 17'd52057;
         3:       mant = 17'd46396;
         4:       mant = 17'd41350;
         default: mant = 17'd36854;
      endcase
      return mant >> (code / DB_PER_OCT);
   endfunction

endpackage

// File: rtl/vr_mix.sv
module vr_mix #(
   parameter int DW = 24
) (
   input  logic signed [DW-1:0] own_in,
   input  logic signed [DW-1:0] opp_in,
   input  logic [1:0]           sel,
   output logic signed [DW-1:0] mixed,
   output logic                 src_muted
);
   import vr_pkg::*;

   logic signed [DW:0] sum_w;

   always_comb begin
      sum_w     = {own_in[DW-1], own_in} + {opp_in[DW-1], opp_in};
      src_muted = 1'b0;
      case (src_sel_e'(sel))
         SRC_OWN:   mixed = own_in;
         SRC_CROSS: mixed = opp_in;
         SRC_AVG:   mixed = DW'(sum_w >>> 1);
         default: begin
            mixed     = '0;
            src_muted = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/vr_level.sv
module vr_level #(
   parameter int CW      = 7,
   parameter int MAX_DB  = 90,
   parameter int TIMEOUT = 512
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          strobe,
   input  logic [CW-1:0] target_raw,
   input  logic [1:0]    mode,
   input  logic          sign_now,
   output logic [CW-1:0] code_next,
   output logic [CW-1:0] code_q
);
   import vr_pkg::*;

   localparam int            TW        = $clog2(TIMEOUT);
   localparam logic [CW-1:0] MUTE_CODE = CW'(MAX_DB + 1);

   logic [CW-1:0] tgt;
   logic [CW-1:0] step_code;
   logic [CW-1:0] nxt;
   logic [TW-1:0] wait_q;
   logic          sign_q;
   logic          pending;
   logic          gate;
   logic          zc_mode;

   always_comb begin
      tgt       = (target_raw > CW'(MAX_DB)) ? MUTE_CODE : target_raw;
      pending   = (code_q != tgt);
      gate      = (sign_now != sign_q) || (wait_q == TW'(TIMEOUT - 1));
      step_code = (tgt > code_q) ? code_q + CW'(1) : code_q - CW'(1);
      zc_mode   = 1'b0;
      case (upd_mode_e'(mode))
         UPD_NOW:  nxt = tgt;
         UPD_RAMP: nxt = pending ? step_code : code_q;
         UPD_ZC: begin
            zc_mode = 1'b1;
            nxt     = (pending && gate) ? tgt : code_q;
         end
         default: begin
            zc_mode = 1'b1;
            nxt     = (pending && gate) ? step_code : code_q;
         end
      endcase
      code_next = strobe ? nxt : code_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         wait_q <= '0;
         sign_q <= 1'b0;
      end else if (strobe) begin
         code_q <= nxt;
         sign_q <= sign_now;
         if (!pending || !zc_mode || (nxt != code_q)) wait_q <= '0;
         else                                         wait_q <= wait_q + TW'(1);
      end
   end

endmodule

// File: rtl/vr_gain.sv
module vr_gain #(
   parameter int DW     = 24,
   parameter int CW     = 7,
   parameter int MAX_DB = 90
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 strobe,
   input  logic signed [DW-1:0] mixed,
   input  logic [CW-1:0]        code,
   input  logic                 force_zero,
   output logic signed [DW-1:0] y
);
   import vr_pkg::*;

   localparam int PW = DW + GAIN_FRAC + 2;

   logic [GAIN_FRAC:0]  g;
   logic signed [PW-1:0] prod;

   always_comb begin
      g    = gain_q(int'(code), MAX_DB);
      prod = PW'(mixed) * PW'($signed({1'b0, g}));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      y <= '0;
      else if (strobe) y <= force_zero ? '0 : DW'(prod >>> GAIN_FRAC);
   end

endmodule

// File: rtl/vr_stereo_gain.sv
module vr_stereo_gain #(
   parameter int DW      = 24,
   parameter int CW      = 7,
   parameter int MAX_DB  = 90,
   parameter int TIMEOUT = 512
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_valid,
   input  logic signed [DW-1:0] in_l,
   input  logic signed [DW-1:0] in_r,
   input  logic [CW-1:0]        atten_a,
   input  logic [CW-1:0]        atten_b,
   input  logic [1:0]           mix_a,
   input  logic [1:0]           mix_b,
   input  logic [1:0]           upd_mode,
   input  logic                 mute_a,
   input  logic                 mute_b,
   output logic                 out_valid,
   output logic signed [DW-1:0] out_a,
   output logic signed [DW-1:0] out_b,
   output logic                 mute_flag_a,
   output logic                 mute_flag_b
);
   localparam int NCH = 2;

   if (TIMEOUT < 512 || TIMEOUT > 1024) begin : g_bad_timeout
      $error("vr_stereo_gain: TIMEOUT must lie in 512..1024");
   end
   if (MAX_DB + 1 >= (1 << CW)) begin : g_bad_code_width
      $error("vr_stereo_gain: CW too narrow for MAX_DB plus mute code");
   end
   if (DW < 2) begin : g_bad_width
      $error("vr_stereo_gain: DW must be at least 2");
   end

   logic signed [DW-1:0] samp   [NCH];
   logic [CW-1:0]        att    [NCH];
   logic [1:0]           sel    [NCH];
   logic                 mbit   [NCH];
   logic signed [DW-1:0] y      [NCH];
   logic                 mflag  [NCH];
   logic [NCH-1:0][CW-1:0] cur_code;

   assign samp[0] = in_l;
   assign samp[1] = in_r;
   assign att[0]  = atten_a;
   assign att[1]  = atten_b;
   assign sel[0]  = mix_a;
   assign sel[1]  = mix_b;
   assign mbit[0] = mute_a;
   assign mbit[1] = mute_b;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic signed [DW-1:0] mixed;
      logic                 src_muted;
      logic [CW-1:0]        code_next;

      vr_mix #(.DW(DW)) u_mix (
         .own_in    (samp[ch]),
         .opp_in    (samp[NCH-1-ch]),
         .sel       (sel[ch]),
         .mixed     (mixed),
         .src_muted (src_muted)
      );

      vr_level #(.CW(CW), .MAX_DB(MAX_DB), .TIMEOUT(TIMEOUT)) u_level (
         .clk        (clk),
         .rst_n      (rst_n),
         .strobe     (smp_valid),
         .target_raw (att[ch]),
         .mode       (upd_mode),
         .sign_now   (mixed[DW-1]),
         .code_next  (code_next),
         .code_q     (cur_code[ch])
      );

      vr_gain #(.DW(DW), .CW(CW), .MAX_DB(MAX_DB)) u_gain (
         .clk        (clk),
         .rst_n      (rst_n),
         .strobe     (smp_valid),
         .mixed      (mixed),
         .code       (code_next),
         .force_zero (src_muted | mbit[ch]),
         .y          (y[ch])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) mflag[ch] <= 1'b0;
         else        mflag[ch] <= mbit[ch] | src_muted;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= smp_valid;
   end

   assign out_a       = y[0];
   assign out_b       = y[1];
   assign mute_flag_a = mflag[0];
   assign mute_flag_b = mflag[1];

endmodule

// File: rtl/vr_stereo_gain_chk.sv
module vr_stereo_gain_chk #(
   parameter int DW = 24,
   parameter int CW = 7
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 smp_valid,
   input logic                 mute_a,
   input logic                 mute_b,
   input logic [1:0]           upd_mode,
   input logic                 out_valid,
   input logic signed [DW-1:0] out_a,
   input logic signed [DW-1:0] out_b,
   input logic                 mute_flag_a,
   input logic                 mute_flag_b,
   input logic [CW-1:0]        cur_a,
   input logic [CW-1:0]        cur_b
);

   a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> out_valid);

   a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> !out_valid);

   a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> ($stable(out_a) && $stable(out_b)));

   a_r4_mute_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && mute_a) |=> (out_a == '0));

   a_r4_mute_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && mute_b) |=> (out_b == '0));

   a_r4_flag_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (mute_a |=> mute_flag_a));

   a_r6_level_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> ($stable(cur_a) && $stable(cur_b)));

   a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && upd_mode == 2'd1) |=>
         ((cur_a == $past(cur_a)) || (cur_a == $past(cur_a) + CW'(1)) ||
          (cur_a + CW'(1) == $past(cur_a))));

endmodule

bind vr_stereo_gain vr_stereo_gain_chk #(.DW(DW), .CW(CW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .smp_valid   (smp_valid),
   .mute_a      (mute_a),
   .mute_b      (mute_b),
   .upd_mode    (upd_mode),
   .out_valid   (out_valid),
   .out_a       (out_a),
   .out_b       (out_b),
   .mute_flag_a (mute_flag_a),
   .mute_flag_b (mute_flag_b),
   .cur_a       (cur_code[0]),
   .cur_b       (cur_code[1])
);

// File: tb/tb_vr_stereo_gain.sv
`timescale 1ns/1ps
module tb_vr_stereo_gain;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               smp_valid = 1'b0;
   logic signed [23:0] in_l = '0, in_r = '0;
   logic [6:0]         atten_a = '0, atten_b = '0;
   logic [1:0]         mix_a = 2'd1, mix_b = 2'd1;
   logic [1:0]         upd_mode = 2'd0;
   logic               mute_a = 1'b0, mute_b = 1'b0;
   logic               out_valid;
   logic signed [23:0] out_a, out_b;
   logic               mute_flag_a, mute_flag_b;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   vr_stereo_gain dut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .in_l(in_l), .in_r(in_r),
      .atten_a(atten_a), .atten_b(atten_b), .mix_a(mix_a), .mix_b(mix_b),
      .upd_mode(upd_mode), .mute_a(mute_a), .mute_b(mute_b),
      .out_valid(out_valid), .out_a(out_a), .out_b(out_b),
      .mute_flag_a(mute_flag_a), .mute_flag_b(mute_flag_b)
   );

   typedef struct packed {
      logic signed [23:0] l;
      logic signed [23:0] r;
      logic [1:0]         sa;
      logic [1:0]         sb;
      logic [6:0]         ca;
      logic [6:0]         cb;
      logic               ma;
      logic               mb;
      logic signed [23:0] ea;
      logic signed [23:0] eb;
      logic               fa;
      logic               fb;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{ 24'sd1048576, -24'sd1048576, 2'd1, 2'd1, 7'd0,  7'd0,   1'b0, 1'b0,  24'sd1048576, -24'sd1048576, 1'b0, 1'b0},
      '{ 24'sd1048576, -24'sd1048576, 2'd1, 2'd1, 7'd6,  7'd12,  1'b0, 1'b0,  24'sd524288,  -24'sd262144,  1'b0, 1'b0},
      '{ 24'sd1048576, -24'sd1048576, 2'd1, 2'd1, 7'd1,  7'd3,   1'b0, 1'b0,  24'sd934544,  -24'sd742336,  1'b0, 1'b0},
      '{ 24'sd1048576, -24'sd1048576, 2'd2, 2'd2, 7'd0,  7'd0,   1'b0, 1'b0, -24'sd1048576,  24'sd1048576, 1'b0, 1'b0},
      '{ 24'sd1048576,  24'sd3145728, 2'd3, 2'd3, 7'd0,  7'd6,   1'b0, 1'b0,  24'sd2097152,  24'sd1048576, 1'b0, 1'b0},
      '{-24'sd1,        24'sd0,       2'd3, 2'd1, 7'd0,  7'd0,   1'b0, 1'b0, -24'sd1,        24'sd0,       1'b0, 1'b0},
      '{ 24'sd1048576,  24'sd1048576, 2'd0, 2'd1, 7'd0,  7'd90,  1'b0, 1'b0,  24'sd0,         24'sd32,      1'b1, 1'b0},
      '{ 24'sd1048576,  24'sd1048576, 2'd1, 2'd1, 7'd91, 7'd127, 1'b0, 1'b0,  24'sd0,         24'sd0,       1'b0, 1'b0},
      '{ 24'sd1048576,  24'sd1048576, 2'd1, 2'd1, 7'd0,  7'd2,   1'b1, 1'b0,  24'sd0,         24'sd832912,  1'b1, 1'b0},
      '{ 24'sd8388607,  24'sd8388607, 2'd3, 2'd3, 7'd0,  7'd6,   1'b0, 1'b0,  24'sd8388607,  24'sd4194303, 1'b0, 1'b0}
   };

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one strobe; returns at the next falling edge, where the result is visible
   task automatic strobe(input logic signed [23:0] l, input logic signed [23:0] r);
      @(negedge clk);
      in_l = l; in_r = r; smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 reset out_a", out_a, 0);
      chk("R11 reset out_b", out_b, 0);
      chk("R11 reset out_valid", out_valid, 0);
      chk("R11 reset flags", {mute_flag_a, mute_flag_b}, 0);
      rst_n = 1'b1;

      // vector table, immediate mode (R1 R2 R3 R4 R6)
      upd_mode = 2'd0;
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         mix_a = VECS[i].sa; mix_b = VECS[i].sb;
         atten_a = VECS[i].ca; atten_b = VECS[i].cb;
         mute_a = VECS[i].ma; mute_b = VECS[i].mb;
         strobe(VECS[i].l, VECS[i].r);
         chk($sformatf("R1 R3 R6 vec%0d out_a", i), out_a, VECS[i].ea);
         chk($sformatf("R2 R3 R6 vec%0d out_b", i), out_b, VECS[i].eb);
         chk($sformatf("R4 vec%0d flag_a", i), mute_flag_a, VECS[i].fa);
         chk($sformatf("R4 vec%0d flag_b", i), mute_flag_b, VECS[i].fb);
         chk($sformatf("R5 vec%0d valid", i), out_valid, 1);
      end

      // R5: outputs hold and valid drops between strobes
      @(negedge clk);
      chk("R5 valid low idle", out_valid, 0);
      chk("R5 hold out_b", out_b, 4194303);

      // R7 soft ramp: A 0 -> 3, B stays at 6
      mix_a = 2'd1; mix_b = 2'd1; mute_a = 1'b0; mute_b = 1'b0;
      upd_mode = 2'd1; atten_a = 7'd3; atten_b = 7'd6;
      strobe(24'sd1048576, 24'sd1048576);
      chk("R7 ramp step1", out_a, 934544);
      chk("R7 ramp B held", out_b, 524288);
      strobe(24'sd1048576, 24'sd1048576);
      chk("R7 ramp step2", out_a, 832912);
      strobe(24'sd1048576, 24'sd1048576);
      chk("R7 ramp step3", out_a, 742336);
      strobe(24'sd1048576, 24'sd1048576);
      chk("R7 ramp at target", out_a, 742336);
      atten_a = 7'd1;
      strobe(24'sd1048576, 24'sd1048576);
      chk("R7 ramp upward", out_a, 832912);

      upd_mode = 2'd0; atten_a = 7'd0;
      strobe(24'sd1048576, 24'sd1048576);
      chk("R6 immediate back to 0dB", out_a, 1048576);

      // R8 zero cross, per channel
      upd_mode = 2'd2; atten_a = 7'd6; atten_b = 7'd0;
      strobe(24'sd1048576, 24'sd1048576);
      chk("R8 no cross A waits", out_a, 1048576);
      chk("R8 no cross B waits", out_b, 524288);
      strobe(-24'sd1048576, 24'sd1048576);
      chk("R8 A cross applies on crossing sample", out_a, -524288);
      chk("R8 B unaffected by A crossing", out_b, 524288);
      strobe(-24'sd1048576, -24'sd1048576);
      chk("R8 A steady", out_a, -524288);
      chk("R8 B cross applies", out_b, -1048576);

      // R9 timeout
      strobe(24'sd1048576, 24'sd1048576);
      chk("R9 settle A", out_a, 524288);
      atten_a = 7'd0;
      for (int k = 0; k < 511; k++) strobe(24'sd1048576, 24'sd1048576);
      chk("R9 before timeout", out_a, 524288);
      strobe(24'sd1048576, 24'sd1048576);
      chk("R9 forced at timeout", out_a, 1048576);

      // R10 ramp with zero cross
      upd_mode = 2'd3; atten_a = 7'd2;
      strobe(-24'sd1048576, 24'sd1048576);
      chk("R10 step on crossing 1", out_a, -934544);
      strobe(24'sd1048576, 24'sd1048576);
      chk("R10 step on crossing 2", out_a, 832912);
      strobe(-24'sd1048576, 24'sd1048576);
      chk("R10 at target", out_a, -832912);
      atten_a = 7'd0;
      strobe(-24'sd1048576, 24'sd1048576);
      chk("R10 no crossing holds", out_a, -832912);

      // R4 flag follows mute bit without strobe
      @(negedge clk); mute_b = 1'b1;
      @(negedge clk);
      chk("R4 flag_b set", mute_flag_b, 1);
      mute_b = 1'b0;
      @(negedge clk);
      chk("R4 flag_b cleared", mute_flag_b, 0);

      // R11 reset restores 0 dB level
      rst_n = 1'b0;
      @(negedge clk);
      chk("R11 mid reset out_a", out_a, 0);
      chk("R11 mid reset valid", out_valid, 0);
      rst_n = 1'b1;
      upd_mode = 2'd1; atten_a = 7'd2;
      strobe(24'sd1048576, 24'sd1048576);
      chk("R11 level restarts from code 0", out_a, 934544);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule